// File: doc/BRIEF.md
# Windowed Mean-Absolute-Value Silence Detector

This block is the first gate in a low-power neural recording chain. Each sample period it takes one signed sample from each of four neighbouring recording channels. It merges them into one virtual channel by averaging, and adds the magnitude of that virtual sample into a window total. After a fixed number of virtual samples it publishes the total and compares it with a programmable threshold. A registered wake flag follows from that compare: high lets a downstream radio and codec carry the data, low keeps them powered off.

The datapath uses adders, a magnitude stage and one comparator, and no multiplier. The four captured channel samples go through a single multiplexer into one shared adder over four clock cycles. The divide by four is an arithmetic shift. The threshold is applied to the raw window total, so no divider is needed either. At 2 kHz sampling and 32 samples per window, a decision comes every 16 ms. The 80 kHz logic clock leaves 40 cycles per sample, and one sample takes 5 of them.

Top module: `mav_silence_detector`

## Requirements
- R1: During and after synchronous reset, `mav_sum` is 0, `mav_valid` is 0 and `wake` is 0.
- R2: Channel k sits in bits [12k+11:12k] of `smp_bus` as signed two's complement. The virtual sample is floor((ch0+ch1+ch2+ch3)/4), rounding toward negative infinity: a channel sum of -5 gives -2.
- R3: The magnitude of a virtual sample of -2048 saturates to 2047. All other values give their exact absolute value.
- R4: The window total is the sum of 32 virtual-sample magnitudes. It appears on `mav_sum` with a one-cycle `mav_valid` pulse, visible after the fifth rising edge following the edge that accepts the 32nd strobe.
- R5: At each `mav_valid`, `wake` becomes 1 when the window total is greater than or equal to the threshold, including exact equality.
- R6: At each `mav_valid`, `wake` becomes 0 when the window total is below the threshold.
- R7: `wake` and `mav_sum` hold their values in every cycle without `mav_valid`.
- R8: The window total restarts from zero after each report, so a window's result does not depend on earlier windows.
- R9: A strobe that arrives during the four cycles in which an accepted sample is being summed is ignored. It does not add a sample and does not advance the window count.
- R10: A threshold write (`thr_wr`) takes effect only when no sample is in flight, that is not within the five cycles after an accepted strobe. A write in that span is dropped.
- R11: A window of full-scale samples (magnitude 2047 every time) reports 65504 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle pulse: a new set of channel samples is on `smp_bus` |
| smp_bus | input | 48 | Four signed 12-bit channel samples, channel 0 in the low bits |
| thr_wr | input | 1 | Threshold load request |
| thr_in | input | 16 | Threshold value, compared with the raw window total |
| mav_sum | output | 16 | Most recent window total of virtual-sample magnitudes |
| mav_valid | output | 1 | One-cycle pulse marking a fresh `mav_sum` and `wake` decision |
| wake | output | 1 | High to enable the downstream transmitter, low to keep it off |

## Verification
The bench aims at the rounding of negative channel sums. A divider that truncated toward zero would report a smaller total for the alternating -5 and -1 pattern. All-minimum inputs exercise the saturating magnitude, and an unsaturated design would wrap the -2048 average and report a wrong or overflowed total. A threshold exactly equal to the total separates greater-or-equal from strictly-greater. Extra strobes and threshold writes placed in the busy span would, if accepted, end the window early or move the wake decision.

// File: rtl/mavsd_pkg.sv
package mavsd_pkg;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_SUM  = 1'b1
  } chan_state_e;

endpackage

// File: rtl/mavsd_chan_avg.sv
module mavsd_chan_avg
  import mavsd_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int NCH   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stb,
  input  logic [NCH*SMP_W-1:0]    smp_bus,
  output logic                    busy,
  output logic                    vc_valid,
  output logic signed [SMP_W-1:0] vc_data
);
  localparam int SHIFT = $clog2(NCH);
  localparam int SUM_W = SMP_W + SHIFT;
  localparam int IDX_W = (SHIFT > 0) ? SHIFT : 1;

  chan_state_e             state;
  logic [IDX_W-1:0]        idx;
  logic signed [SMP_W-1:0] cap [NCH];
  logic signed [SUM_W-1:0] csum;
  logic signed [SMP_W-1:0] cur;
  logic signed [SUM_W-1:0] sum_nx;

  assign busy   = (state == CS_SUM);
  assign cur    = cap[idx];
  assign sum_nx = csum + SUM_W'(cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCH; k++) cap[k] <= '0;
    end else if (state == CS_IDLE && stb) begin
      for (int k = 0; k < NCH; k++) cap[k] <= smp_bus[k*SMP_W +: SMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CS_IDLE;
      idx      <= '0;
      csum     <= '0;
      vc_valid <= 1'b0;
      vc_data  <= '0;
    end else begin
      vc_valid <= 1'b0;
      case (state)
        CS_IDLE: begin
          if (stb) begin
            state <= CS_SUM;
            idx   <= '0;
            csum  <= '0;
          end
        end
        default: begin
          csum <= sum_nx;
          idx  <= idx + 1'b1;
          if (idx == IDX_W'(NCH - 1)) begin
            state    <= CS_IDLE;
            vc_valid <= 1'b1;
            vc_data  <= sum_nx[SUM_W-1:SHIFT];
          end
        end
      endcase
    end
  end

  assert_vc_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    vc_valid |=> !vc_valid);

  assert_vc_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(vc_valid) |-> !busy && $past(busy));

endmodule

// File: rtl/mavsd_abs.sv
module mavsd_abs #(
  parameter int W = 12
) (
  input  logic signed [W-1:0] din,
  output logic [W-2:0]        mag
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] neg;

  assign neg = ~din + 1'b1;

  always_comb begin
    if (din == MOST_NEG) mag = '1;
    else if (din[W-1])   mag = neg[W-2:0];
    else                 mag = din[W-2:0];
  end

endmodule

// File: rtl/mavsd_window.sv
module mavsd_window #(
  parameter int MAG_W   = 11,
  parameter int WIN_LEN = 32,
  parameter int ACC_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [MAG_W-1:0] mag,
  input  logic [ACC_W-1:0] thr,
  output logic [ACC_W-1:0] mav_sum,
  output logic             mav_valid,
  output logic             wake
);
  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [ACC_W:0] SUM_CAP =
    (ACC_W+1)'(WIN_LEN) * (ACC_W+1)'((1 << MAG_W) - 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_nx;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign acc_nx = acc + ACC_W'(mag);
  assign last   = (cnt == CNT_W'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      mav_sum   <= '0;
      mav_valid <= 1'b0;
      wake      <= 1'b0;
    end else begin
      mav_valid <= 1'b0;
      if (in_valid) begin
        if (last) begin
          mav_sum   <= acc_nx;
          mav_valid <= 1'b1;
          wake      <= (acc_nx >= thr);
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_nx;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mav_valid |=> !mav_valid);

  assert_wake_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !mav_valid |-> $stable(wake) && $stable(mav_sum));

  assert_wake_decision_R5: assert property (@(posedge clk) disable iff (rst)
    mav_valid |-> (wake == (mav_sum >= thr)));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    mav_valid |-> ({1'b0, mav_sum} <= SUM_CAP));

endmodule

// File: rtl/mav_silence_detector.sv
module mav_silence_detector #(
  parameter  int SMP_W   = 12,
  parameter  int NCH     = 4,
  parameter  int WIN_LEN = 32,
  localparam int MAG_W   = SMP_W - 1,
  localparam int ACC_W   = MAG_W + $clog2(WIN_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic [NCH*SMP_W-1:0] smp_bus,
  input  logic                 thr_wr,
  input  logic [ACC_W-1:0]     thr_in,
  output logic [ACC_W-1:0]     mav_sum,
  output logic                 mav_valid,
  output logic                 wake
);
  logic                    busy;
  logic                    vc_valid;
  logic signed [SMP_W-1:0] vc_data;
  logic [MAG_W-1:0]        vc_mag;
  logic [ACC_W-1:0]        thr_q;
  logic                    idle;

  assign idle = !busy && !vc_valid;

  always_ff @(posedge clk) begin
    if (rst)                 thr_q <= '0;
    else if (thr_wr && idle) thr_q <= thr_in;
  end

  mavsd_chan_avg #(.SMP_W(SMP_W), .NCH(NCH)) u_avg (
    .clk      (clk),
    .rst      (rst),
    .stb      (smp_stb),
    .smp_bus  (smp_bus),
    .busy     (busy),
    .vc_valid (vc_valid),
    .vc_data  (vc_data)
  );

  mavsd_abs #(.W(SMP_W)) u_abs (
    .din (vc_data),
    .mag (vc_mag)
  );

  mavsd_window #(.MAG_W(MAG_W), .WIN_LEN(WIN_LEN), .ACC_W(ACC_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (vc_valid),
    .mag       (vc_mag),
    .thr       (thr_q),
    .mav_sum   (mav_sum),
    .mav_valid (mav_valid),
    .wake      (wake)
  );

  assert_thr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(thr_q));

endmodule

// File: tb/tb_mav_silence_detector.sv
module tb_mav_silence_detector;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [47:0] smp_bus = '0;
  logic        thr_wr = 1'b0;
  logic [15:0] thr_in = '0;
  logic [15:0] mav_sum;
  logic        mav_valid;
  logic        wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int nval, vat, vsum, hold_err, hold_sum;
  bit hold_wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  mav_silence_detector dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_bus(smp_bus),
    .thr_wr(thr_wr), .thr_in(thr_in),
    .mav_sum(mav_sum), .mav_valid(mav_valid), .wake(wake)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int vmag(int a, int b, int c, int d);
    int s, v, m;
    s = a + b + c + d;
    v = s >>> 2;
    m = (v < 0) ? -v : v;
    if (m > 2047) m = 2047;
    return m;
  endfunction

  function automatic int chv(int kind, int i, int k);
    case (kind)
      0: return 100;
      1: return (k == 0) ? (((i % 2) == 0) ? -5 : -1) : 0;
      2: return -2048;
      3: return 2047;
      default: begin
        case (k)
          0: return i*37 - 500;
          1: return 3*i;
          2: return -11*i;
          default: return 200 - i;
        endcase
      end
    endcase
  endfunction

  task automatic write_thr(int v);
    @(negedge clk);
    thr_wr = 1'b1;
    thr_in = 16'(v);
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  // one accepted sample; optional extra strobe and threshold write while busy
  task automatic push(int a, int b, int c, int d, bit dup, bit wr_busy, bit is_last);
    @(negedge clk);
    smp_bus = {12'(d), 12'(c), 12'(b), 12'(a)};
    smp_stb = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (mav_valid) begin
        nval++;
        vsum = mav_sum;
        if (is_last) vat = n;
        hold_sum  = mav_sum;
        hold_wake = wake;
      end else if (mav_sum != 16'(hold_sum) || wake != hold_wake) begin
        hold_err++;
      end
      if (n == 1) begin
        smp_stb = dup;
        smp_bus = {4{12'sd2047}};
        if (wr_busy) begin
          thr_wr = 1'b1;
          thr_in = 16'd0;
        end
      end
      if (n == 2) begin
        smp_stb = 1'b0;
        thr_wr  = 1'b0;
      end
    end
  endtask

  task automatic run_window(string tag, int kind, int thr, bit noise);
    int exp_sum;
    exp_sum = 0;
    nval = 0; vat = 0; vsum = -1; hold_err = 0;
    write_thr(thr);
    for (int i = 0; i < WIN; i++) begin
      exp_sum += vmag(chv(kind, i, 0), chv(kind, i, 1), chv(kind, i, 2), chv(kind, i, 3));
      push(chv(kind, i, 0), chv(kind, i, 1), chv(kind, i, 2), chv(kind, i, 3),
           noise, noise, i == WIN - 1);
    end
    chk({tag, " R4 one valid pulse per window"}, nval, 1);
    chk({tag, " R4 valid cycle after last strobe"}, vat, 6);
    chk({tag, " R2 R3 R8 window sum"}, vsum, exp_sum);
    chk({tag, " R5 R6 wake vs threshold"}, int'(wake), int'(exp_sum >= thr));
    chk({tag, " R7 outputs held between reports"}, hold_err, 0);
  endtask

  initial begin
    hold_sum = 0;
    hold_wake = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset mav_sum", int'(mav_sum), 0);
    chk("R1 reset wake", int'(wake), 0);
    chk("R1 reset mav_valid", int'(mav_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release wake", int'(wake), 0);

    run_window("W1 positive R5", 0, 3000, 1'b0);
    run_window("W2 floor rounding R2 R6 R8", 1, 100, 1'b0);
    chk("R2 floor total for -5/-1 pattern", vsum, 48);
    run_window("W3 min saturation R3 equal R5", 2, 65504, 1'b0);
    chk("R3 R11 saturated total", vsum, 65504);
    run_window("W4 full scale R11 R6", 3, 65505, 1'b0);
    chk("R11 full-scale total", vsum, 65504);
    run_window("W5 busy strobes R9 busy write R10", 4, 60000, 1'b1);
    chk("R10 busy write dropped, wake low", int'(wake), 0);
    run_window("W6 idle threshold load R10", 4, 0, 1'b0);
    chk("R10 idle write taken, wake high", int'(wake), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule